// File: doc/BRIEF.md
# Register-Bank Bus Slave with Two-Cycle Error Response

This block is a small memory-mapped slave on a pipelined single-master system bus. It holds a bank of word registers. The upper part of the bank is fixed at its reset contents and cannot be written. A transfer is captured in its address phase. It completes in the following data phase after a fixed number of wait states.

A normal transfer ends with a one-cycle OKAY. A write aimed at a fixed word is refused with the two-cycle ERROR sequence. That sequence gives the master one cycle to withdraw the next beat it has already placed on the bus. Idle and busy cycles are acknowledged at once and change nothing. A burst that the master abandons part-way leaves the slave ready for the next transfer. Byte and halfword writes change only the lanes they address.

Top module: `ahb_regbank_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `readyout_o` is 1, `resp_o` is 0 and `rdata_o` is 0. Word i of the bank holds 0xC0DE0000 + 257*i after reset.
- R2: A selected cycle with `trans_i` = 00 (idle) or 01 (busy) gets a zero-wait OKAY: in the next cycle `readyout_o` is 1 and `resp_o` is 0. No stored word changes.
- R3: A transfer is accepted when `sel_i` and `ready_i` are high and `trans_i` is 10 (first beat) or 11 (following beat). The data-phase cycles that follow begin with WAIT_STATES cycles in which `readyout_o` is 0 and `resp_o` is 0 (OKAY).
- R4: When a transfer does not fail, the wait states are followed by a single cycle with `readyout_o` = 1 and `resp_o` = 0.
  - For a read, `rdata_o` carries the addressed word in that cycle and is 0 in every other cycle.
  - For a write, `wdata_i` from that cycle is stored at its end.
- R5: When a transfer fails, the wait states are followed by two cycles. The first has `resp_o` = 1 and `readyout_o` = 0. The second has `resp_o` = 1 and `readyout_o` = 1.
- R6: Words with index at or above RO_FIRST (default 12) are read-only. A write to one of them takes the error path of R5 and leaves its contents unchanged. Reads of these words complete as in R4.
- R7: `addr_i[5:2]` selects the word and `addr_i[1:0]` is the byte offset.
- R8: `size_i` sets the write width: 0 is one byte, 1 is a halfword, 2 is a full word. A write updates only the byte lanes inside the aligned group of that width that contains the offset. Lane b is bits 8b+7..8b.
- R9: A cycle with `sel_i` low starts no transfer, whatever `trans_i` holds.
- R10: The slave handles a burst cut short during an ERROR.
  - A beat presented during the first ERROR cycle, then replaced by idle in the second, is never performed.
  - A first-beat transfer presented in the second ERROR cycle is accepted and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Slave select for the address phase |
| addr_i | input | 6 | Byte address |
| trans_i | input | 2 | Transfer kind: 00 idle, 01 busy, 10 first beat, 11 following beat |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | Transfer width code |
| wdata_i | input | 32 | Write data, valid in the data phase |
| ready_i | input | 1 | Bus ready: previous transfer has completed |
| rdata_o | output | 32 | Read data |
| readyout_o | output | 1 | Slave ready; low to extend the data phase |
| resp_o | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The address phase is captured at the clock edge where it is accepted. Every result of that transfer lies in a fixed window after that edge: WAIT_STATES wait cycles, then either one OKAY cycle or the two ERROR cycles. The bench drives all inputs on falling edges and samples each data-phase cycle at the falling edge that follows the register update. Its loop counts the wait cycles itself before it expects the completing cycle. Writes are confirmed only through a later read transfer, and idle, busy and unselected cycles are checked at the very next cycle for their zero-wait OKAY.

// File: rtl/ahb_rb_pkg.sv
package ahb_rb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } tr_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_DONE = 3'd2,
    ST_ERR1 = 3'd3,
    ST_ERR2 = 3'd4
  } rsp_st_e;

  // A transfer kind that carries data (first or following beat)
  function automatic logic is_active(logic [1:0] t);
    return (t == TR_NSEQ) || (t == TR_SEQ);
  endfunction

endpackage

// File: rtl/ahb_rb_capture.sv
module ahb_rb_capture
  import ahb_rb_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int OFF_W    = 2,
  parameter int RO_FIRST = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel,
  input  logic                   ready,
  input  logic [1:0]             trans,
  input  logic                   write,
  input  logic [2:0]             size,
  input  logic [IDX_W+OFF_W-1:0] addr,
  output logic                   accept,
  output logic                   start_err,
  output logic                   cap_write,
  output logic                   cap_ro,
  output logic                   cap_err,
  output logic [IDX_W-1:0]       cap_idx,
  output logic [OFF_W-1:0]       cap_off,
  output logic [2:0]             cap_size
);

  function automatic logic idx_is_ro(logic [IDX_W-1:0] i);
    return int'(i) >= RO_FIRST;
  endfunction

  logic [IDX_W-1:0] in_idx;
  logic             in_ro;

  assign in_idx    = addr[IDX_W+OFF_W-1:OFF_W];
  assign in_ro     = idx_is_ro(in_idx);
  assign accept    = sel && ready && is_active(trans);
  assign start_err = write && in_ro;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_write <= 1'b0;
      cap_ro    <= 1'b0;
      cap_idx   <= '0;
      cap_off   <= '0;
      cap_size  <= '0;
    end else if (accept) begin
      cap_write <= write;
      cap_ro    <= in_ro;
      cap_idx   <= in_idx;
      cap_off   <= addr[OFF_W-1:0];
      cap_size  <= size;
    end
  end

  assign cap_err = cap_write && cap_ro;

endmodule

// File: rtl/ahb_rb_resp.sv
module ahb_rb_resp
  import ahb_rb_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic start_err,
  input  logic held_err,
  output logic readyout,
  output logic resp,
  output logic commit
);

  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

  rsp_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE, ST_DONE, ST_ERR2: begin
        if (accept) begin
          if (WAIT_STATES > 0) begin
            st_d  = ST_WAIT;
            cnt_d = CNT_W'(WAIT_STATES - 1);
          end else begin
            st_d = start_err ? ST_ERR1 : ST_DONE;
          end
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) st_d = held_err ? ST_ERR1 : ST_DONE;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_ERR1: st_d = ST_ERR2;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign readyout = !((st_q == ST_WAIT) || (st_q == ST_ERR1));
  assign resp     = (st_q == ST_ERR1) || (st_q == ST_ERR2);
  assign commit   = (st_q == ST_DONE);

endmodule

// File: rtl/ahb_rb_store.sv
module ahb_rb_store #(
  parameter int NUM_WORDS = 16,
  parameter int DATA_W    = 32,
  parameter int RO_FIRST  = 12,
  localparam int STRB_W   = DATA_W / 8,
  localparam int OFF_W    = $clog2(STRB_W),
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  // Reset contents: a fixed tag in the upper half, the index spread into both low bytes
  function automatic logic [DATA_W-1:0] init_word(int i);
    return DATA_W'(32'hC0DE_0000) | DATA_W'(i * 257);
  endfunction

  // Lanes inside the aligned group of 2**size bytes that holds the offset
  function automatic logic [STRB_W-1:0] lane_mask(logic [2:0] sz, logic [OFF_W-1:0] o);
    int nbytes;
    logic [STRB_W-1:0] m;
    nbytes = (int'(sz) > OFF_W) ? STRB_W : (1 << sz);
    m = '0;
    for (int b = 0; b < STRB_W; b++) begin
      if ((b / nbytes) == (int'(o) / nbytes)) m[b] = 1'b1;
    end
    return m;
  endfunction

  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [STRB_W-1:0] lanes;
  logic [DATA_W-1:0] bit_en;

  assign lanes = lane_mask(size, off);

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign bit_en[b*8 +: 8] = {8{lanes[b]}};
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [DATA_W-1:0] INIT  = init_word(w);
    localparam bit                IS_RW = (w < RO_FIRST);
    logic hit;
    assign hit = IS_RW && we && (int'(idx) == w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words[w] <= INIT;
      else if (hit) words[w] <= (words[w] & ~bit_en) | (wdata & bit_en);
    end
  end

  assign rdata = rd_en ? words[idx] : '0;

endmodule

// File: rtl/ahb_regbank_slave.sv
module ahb_regbank_slave
  import ahb_rb_pkg::*;
#(
  parameter int NUM_WORDS   = 16,
  parameter int DATA_W      = 32,
  parameter int RO_FIRST    = 12,
  parameter int WAIT_STATES = 2,
  localparam int STRB_W     = DATA_W / 8,
  localparam int OFF_W      = $clog2(STRB_W),
  localparam int IDX_W      = $clog2(NUM_WORDS),
  localparam int ADDR_W     = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              readyout_o,
  output logic              resp_o
);

  // Named internal events, also observed by the bound checker
  logic             accept;
  logic             start_err;
  logic             cap_write;
  logic             cap_ro;
  logic             cap_err;
  logic [IDX_W-1:0] cap_idx;
  logic [OFF_W-1:0] cap_off;
  logic [2:0]       cap_size;
  logic             commit;
  logic             commit_we;
  logic             commit_rd;
  logic             commit_ro;

  ahb_rb_capture #(
    .IDX_W    (IDX_W),
    .OFF_W    (OFF_W),
    .RO_FIRST (RO_FIRST)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel_i),
    .ready     (ready_i),
    .trans     (trans_i),
    .write     (write_i),
    .size      (size_i),
    .addr      (addr_i),
    .accept    (accept),
    .start_err (start_err),
    .cap_write (cap_write),
    .cap_ro    (cap_ro),
    .cap_err   (cap_err),
    .cap_idx   (cap_idx),
    .cap_off   (cap_off),
    .cap_size  (cap_size)
  );

  ahb_rb_resp #(
    .WAIT_STATES (WAIT_STATES)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .start_err (start_err),
    .held_err  (cap_err),
    .readyout  (readyout_o),
    .resp      (resp_o),
    .commit    (commit)
  );

  assign commit_we = commit && cap_write;
  assign commit_rd = commit && !cap_write;
  assign commit_ro = cap_ro;

  ahb_rb_store #(
    .NUM_WORDS (NUM_WORDS),
    .DATA_W    (DATA_W),
    .RO_FIRST  (RO_FIRST)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_we),
    .rd_en (commit_rd),
    .idx   (cap_idx),
    .off   (cap_off),
    .size  (cap_size),
    .wdata (wdata_i),
    .rdata (rdata_o)
  );

endmodule

// File: rtl/ahb_regbank_checker.sv
module ahb_regbank_checker #(
  parameter int WAIT_STATES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic readyout_o,
  input logic resp_o,
  input logic accept,
  input logic commit_we,
  input logic commit_ro
);

  // Cycle counter since the last accepted address phase
  int unsigned since;
  logic        track;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track <= 1'b0;
      since <= 0;
    end else if (accept) begin
      track <= 1'b1;
      since <= 0;
    end else if (track) begin
      if (since + 1 >= WAIT_STATES) track <= 1'b0;
      since <= since + 1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (readyout_o && !resp_o));

  p_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (readyout_o && !accept) |=> (readyout_o && !resp_o));

  p_wait_okay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (track && (since < WAIT_STATES)) |-> (!readyout_o && !resp_o));

  p_err_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o && !readyout_o) |=> (resp_o && readyout_o));

  p_err_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o && readyout_o) |-> $past(resp_o && !readyout_o));

  p_no_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> !commit_ro);

endmodule

bind ahb_regbank_slave ahb_regbank_checker #(
  .WAIT_STATES (WAIT_STATES)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .readyout_o (readyout_o),
  .resp_o     (resp_o),
  .accept     (accept),
  .commit_we  (commit_we),
  .commit_ro  (commit_ro)
);

// File: tb/ahb_regbank_slave_bench.sv
module ahb_regbank_slave_bench;

  localparam int NW = 16;
  localparam int RO = 12;
  localparam int W  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [5:0]  addr = '0;
  logic [1:0]  trans = 2'b00;
  logic        write = 1'b0;
  logic [2:0]  size = 3'd2;
  logic [31:0] wdata = '0;
  logic        bus_ready;
  logic [31:0] rdata;
  logic        readyout;
  logic        resp;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [NW];

  always #5 clk = ~clk;
  assign bus_ready = readyout;

  ahb_regbank_slave u_ahb_regbank_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel),
    .addr_i     (addr),
    .trans_i    (trans),
    .write_i    (write),
    .size_i     (size),
    .wdata_i    (wdata),
    .ready_i    (bus_ready),
    .rdata_o    (rdata),
    .readyout_o (readyout),
    .resp_o     (resp)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_write(int idx, int off, int sz, logic [31:0] wd);
    int nb;
    int lo;
    nb = 1 << sz;
    lo = off - (off % nb);
    for (int b = 0; b < 4; b++)
      if (b >= lo && b < lo + nb) model[idx][b*8 +: 8] = wd[b*8 +: 8];
  endtask

  task automatic addr_phase(bit wr, int idx, int off, int sz);
    sel   = 1'b1;
    trans = 2'b10;
    write = wr;
    addr  = 6'(idx * 4 + off);
    size  = 3'(sz);
  endtask

  // Called at the falling edge right after the address phase was taken
  task automatic data_phase(bit wr, int idx, int off, int sz, logic [31:0] wd, string req);
    bit err;
    err   = wr && (idx >= RO);
    sel   = 1'b0;
    trans = 2'b00;
    wdata = wd;
    for (int c = 0; c < W; c++) begin
      if (c > 0) @(negedge clk);
      chk("R3", "wait readyout", 32'(readyout), 32'd0);
      chk("R3", "wait resp", 32'(resp), 32'd0);
      chk("R4", "rdata idle in wait", rdata, 32'd0);
    end
    if (W > 0) @(negedge clk);
    if (err) begin
      chk("R5", "err1 readyout", 32'(readyout), 32'd0);
      chk("R5", "err1 resp", 32'(resp), 32'd1);
      @(negedge clk);
      chk("R5", "err2 readyout", 32'(readyout), 32'd1);
      chk("R5", "err2 resp", 32'(resp), 32'd1);
    end else begin
      chk(req, "okay readyout", 32'(readyout), 32'd1);
      chk(req, "okay resp", 32'(resp), 32'd0);
      if (!wr) chk(req, "read data", rdata, model[idx]);
      else     model_write(idx, off, sz, wd);
    end
  endtask

  task automatic xfer(bit wr, int idx, int off, int sz, logic [31:0] wd, string req);
    @(negedge clk);
    addr_phase(wr, idx, off, sz);
    @(negedge clk);
    data_phase(wr, idx, off, sz, wd, req);
  endtask

  task automatic err_then_cut(bit restart, int nidx, logic [31:0] nwd);
    @(negedge clk);
    addr_phase(1'b1, 13, 0, 2);
    @(negedge clk);
    sel = 1'b0; trans = 2'b00; wdata = 32'hDEAD_BEEF;
    for (int c = 0; c < W; c++) begin
      if (c > 0) @(negedge clk);
      chk("R3", "cut wait readyout", 32'(readyout), 32'd0);
    end
    if (W > 0) @(negedge clk);
    chk("R5", "cut err1 resp", 32'(resp), 32'd1);
    // next beat already on the bus during the first error cycle
    sel = 1'b1; trans = 2'b11; write = 1'b1; addr = 6'd0; size = 3'd2;
    @(negedge clk);
    chk("R10", "cut err2 readyout", 32'(readyout), 32'd1);
    chk("R10", "cut err2 resp", 32'(resp), 32'd1);
    if (restart) begin
      addr_phase(1'b1, nidx, 0, 2);
      @(negedge clk);
      data_phase(1'b1, nidx, 0, 2, nwd, "R10");
    end else begin
      sel = 1'b0; trans = 2'b00; wdata = 32'h0BAD_0BAD;
      @(negedge clk);
      chk("R10", "cut no transfer readyout", 32'(readyout), 32'd1);
      chk("R10", "cut no transfer resp", 32'(resp), 32'd0);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NW; i++) model[i] = 32'hC0DE_0000 + 32'(i * 257);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "reset readyout", 32'(readyout), 32'd1);
    chk("R1", "reset resp", 32'(resp), 32'd0);
    chk("R1", "reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post reset readyout", 32'(readyout), 32'd1);
    chk("R1", "post reset resp", 32'(resp), 32'd0);

    // R1 R7: reset contents over every word
    for (int i = 0; i < NW; i++) xfer(1'b0, i, 0, 2, 32'd0, "R1");

    // R6 R4: full-word writes everywhere, read-only words refuse
    for (int i = 0; i < NW; i++) xfer(1'b1, i, 0, 2, 32'h5A00_0000 + 32'(i * 32'h0001_0203), "R4");
    for (int i = 0; i < NW; i++) xfer(1'b0, i, 0, 2, 32'd0, (i >= RO) ? "R6" : "R7");

    // R8: byte and halfword lanes
    for (int sz = 0; sz < 2; sz++) begin
      for (int off = 0; off < 4; off += (1 << sz)) begin
        xfer(1'b1, 1, off, sz, 32'h1122_3344 + 32'((off + 4 * sz) * 32'h0101_0101), "R8");
        xfer(1'b0, 1, 0, 2, 32'd0, "R8");
      end
    end
    // R6: narrow write to a read-only word
    xfer(1'b1, 14, 1, 0, 32'hFFFF_FFFF, "R6");
    xfer(1'b0, 14, 0, 2, 32'd0, "R6");

    // R2: idle and busy cycles with select high
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      sel = 1'b1; trans = 2'(k); write = 1'b1; addr = 6'd0; size = 3'd2; wdata = 32'hAAAA_5555;
      @(negedge clk);
      chk("R2", "zero-wait readyout", 32'(readyout), 32'd1);
      chk("R2", "zero-wait resp", 32'(resp), 32'd0);
      sel = 1'b0; trans = 2'b00;
    end
    xfer(1'b0, 0, 0, 2, 32'd0, "R2");

    // R9: unselected first beat is ignored
    @(negedge clk);
    sel = 1'b0; trans = 2'b10; write = 1'b1; addr = 6'd8; size = 3'd2; wdata = 32'h7777_7777;
    @(negedge clk);
    chk("R9", "unselected readyout", 32'(readyout), 32'd1);
    chk("R9", "unselected resp", 32'(resp), 32'd0);
    trans = 2'b00;
    xfer(1'b0, 2, 0, 2, 32'd0, "R9");

    // R10: burst cut by idle, then restarted by a first beat
    err_then_cut(1'b0, 0, 32'd0);
    xfer(1'b0, 0, 0, 2, 32'd0, "R10");
    err_then_cut(1'b1, 5, 32'hFEED_F00D);
    xfer(1'b0, 5, 0, 2, 32'd0, "R10");
    xfer(1'b0, 0, 0, 2, 32'd0, "R10");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule